// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block serves atomic requests against a small local memory that it owns. A request names one of three operations (fetch-and-add, unconditional swap, compare-and-swap), a byte address, an operand size and up to two operands. The block reads the addressed word from its single-port synchronous memory, computes the new value, writes it back when the operation calls for a write, and returns a completion. The completion carries a status and the value the location held before the request. No other memory access can come between the read and the write of one request, because the block takes only one request at a time.

The memory is organised as 128-bit words. Byte address bits above bit 3 select the word, and the low four bits select the lane inside it. The block checks every request before it touches memory. A request with an opcode or size it does not support, or with an address that is not a multiple of the operand size, gets an error status and is never written.

The controller is a four-state machine. IDLE accepts a request: it goes to READ when the request passes the checks (transition *issue*) and straight to RESPOND when it fails (transition *reject*). READ drives the memory read and always goes to MODIFY (transition *fetch*). MODIFY computes the result, writes it when required, and goes to RESPOND (transition *commit*). RESPOND presents the completion for one cycle and returns to IDLE (transition *retire*).

Top module: `atomic_completer`

## Requirements
- R1: During and immediately after reset, `req_ready` is 1 and `cpl_valid` is 0.
- R2: Fetch-and-add (`req_op`=00) returns the old lane value and stores (old + `req_opa`) modulo 2^width in that lane. The carry-out is dropped.
- R3: Unconditional swap (`req_op`=01) returns the old lane value and stores `req_opa` in that lane.
- R4: Compare-and-swap (`req_op`=10) returns the old lane value. It stores `req_opb` only if the old value equals `req_opa`; otherwise the location is left unchanged.
- R5: `req_size` 00 selects 32 bits and 01 selects 64 bits for every operation. 10 selects 128 bits and is valid for compare-and-swap only. Operands are taken from the low bits of `req_opa` and `req_opb`, and `cpl_data` is the old value zero-extended. Only the addressed lane of the 128-bit word, starting at byte `req_addr[3:0]`, changes.
- R6: A supported request whose `req_addr[3:0]` is not a multiple of the operand size in bytes completes with status 10 (malformed) and `cpl_data` zero, and memory is unchanged.
- R7: Opcode 11, size 11, or size 10 with an opcode other than compare-and-swap completes with status 01 (unsupported) and `cpl_data` zero, with no write. This check takes precedence over the alignment check. Status 00 means success.
- R8: The completion is presented 3 cycles after the accepting clock edge for a valid request, and 1 cycle after it for a rejected one.
- R9: From the accepting edge until the completion cycle ends, `req_ready` is 0. `cpl_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is taken on an edge where `req_valid` and this signal are both 1 |
| req_op | input | 2 | Operation: 00 add, 01 swap, 10 compare-and-swap |
| req_size | input | 2 | Operand size: 00 32-bit, 01 64-bit, 10 128-bit |
| req_addr | input | ADDR_W | Byte address |
| req_opa | input | 128 | Add value, swap value, or compare value |
| req_opb | input | 128 | Swap value for compare-and-swap |
| cpl_valid | output | 1 | Completion present (one cycle) |
| cpl_status | output | 2 | 00 success, 01 unsupported, 10 malformed |
| cpl_data | output | 128 | Pre-modification value, zero-extended |

## Verification
A valid request is accepted on one edge, its read is issued in the next cycle, and its write is issued in the cycle after that. Its completion is therefore visible after the third edge counted from acceptance. A rejected request shows its completion after the first edge. The bench drives each request on a falling edge. It then counts falling edges from acceptance until `cpl_valid` appears, checks that this count is exactly 3 or 1, and checks that `req_ready` stays low on every sample before the completion. It samples status and data at that same falling edge, and checks at the next falling edge that the pulse has ended and `req_ready` has returned to 1. Memory contents are compared at the end against a shadow model through read-only fetch-and-add requests with a zero operand.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
    localparam int WORD_W = 128;

    typedef enum logic [1:0] {
        OP_FADD = 2'b00,
        OP_SWAP = 2'b01,
        OP_CAS  = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SZ_32   = 2'b00,
        SZ_64   = 2'b01,
        SZ_128  = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_UNSUP = 2'b01,
        ST_MALF  = 2'b10
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'b00,
        S_READ    = 2'b01,
        S_MODIFY  = 2'b10,
        S_RESPOND = 2'b11
    } fsm_e;
endpackage

// File: rtl/atomic_decode.sv
// Request checker: the unsupported-combination test first, then alignment.
module atomic_decode
    import atomic_pkg::*;
(
    input  op_e        op,
    input  size_e      size,
    input  logic [3:0] byte_off,
    output status_e    status
);
    logic [3:0] align_mask;
    logic       unsupported;

    always_comb begin
        unique case (size)
            SZ_32:   align_mask = 4'h3;
            SZ_64:   align_mask = 4'h7;
            default: align_mask = 4'hF;
        endcase
        unsupported = (op == OP_RSVD) || (size == SZ_RSVD) ||
                      ((size == SZ_128) && (op != OP_CAS));
        if (unsupported)
            status = ST_UNSUP;
        else if ((byte_off & align_mask) != 4'h0)
            status = ST_MALF;
        else
            status = ST_OK;
    end
endmodule

// File: rtl/atomic_alu.sv
// Lane extraction, operation and merge of the new lane back into the word.
module atomic_alu
    import atomic_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [3:0]        byte_off,
    input  op_e               op,
    input  size_e             size,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] old_val,
    output logic [WORD_W-1:0] new_word,
    output logic              wr
);
    logic [WORD_W-1:0] mask, lane_mask, cur, nxt, a_m, b_m;
    logic [6:0]        sh;

    always_comb begin
        unique case (size)
            SZ_32:   mask = {{(WORD_W-32){1'b0}}, {32{1'b1}}};
            SZ_64:   mask = {{(WORD_W-64){1'b0}}, {64{1'b1}}};
            default: mask = {WORD_W{1'b1}};
        endcase
        sh  = {byte_off, 3'b000};
        cur = (word >> sh) & mask;
        a_m = opa & mask;
        b_m = opb & mask;
        wr  = 1'b1;
        nxt = cur;
        unique case (op)
            OP_FADD: nxt = (cur + a_m) & mask;
            OP_SWAP: nxt = a_m;
            OP_CAS: begin
                if (cur == a_m) nxt = b_m;
                else            wr  = 1'b0;
            end
            default: wr = 1'b0;
        endcase
        lane_mask = mask << sh;
        new_word  = (word & ~lane_mask) | (nxt << sh);
        old_val   = cur;
    end
endmodule

// File: rtl/atomic_mem.sv
// Single-port synchronous RAM: one read or one write per cycle.
module atomic_mem #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) store[idx] <= wdata;
            else    rdata      <= store[idx];
        end
    end
endmodule

// File: rtl/atomic_completer.sv
module atomic_completer
    import atomic_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 4,
    localparam int WORDS = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_opa,
    input  logic [WORD_W-1:0] req_opb,
    output logic              cpl_valid,
    output logic [1:0]        cpl_status,
    output logic [WORD_W-1:0] cpl_data
);
    fsm_e              state, state_nxt;
    status_e           dec_status, status_q;
    op_e               op_q;
    size_e             size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] opa_q, opb_q, result_q;
    logic [WORD_W-1:0] rdata, new_word, old_val;
    logic              alu_wr, mem_en, mem_we, accept;

    atomic_decode u_decode (
        .op       (op_e'(req_op)),
        .size     (size_e'(req_size)),
        .byte_off (req_addr[3:0]),
        .status   (dec_status)
    );

    atomic_alu u_alu (
        .word     (rdata),
        .byte_off (addr_q[3:0]),
        .op       (op_q),
        .size     (size_q),
        .opa      (opa_q),
        .opb      (opb_q),
        .old_val  (old_val),
        .new_word (new_word),
        .wr       (alu_wr)
    );

    atomic_mem #(.DEPTH(WORDS), .WIDTH(WORD_W)) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .idx   (addr_q[ADDR_W-1:4]),
        .wdata (new_word),
        .rdata (rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Transitions: issue, reject, fetch, commit, retire
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nxt = (dec_status == ST_OK) ? S_READ : S_RESPOND;
            S_READ:    state_nxt = S_MODIFY;
            S_MODIFY:  state_nxt = S_RESPOND;
            S_RESPOND: state_nxt = S_IDLE;
        endcase
    end

    // Outputs and memory strobes
    always_comb begin
        req_ready  = (state == S_IDLE);
        accept     = req_ready && req_valid;
        cpl_valid  = (state == S_RESPOND);
        cpl_status = status_q;
        cpl_data   = result_q;
        mem_we     = (state == S_MODIFY) && alu_wr;
        mem_en     = (state == S_READ) || mem_we;
    end

    // Request capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            result_q <= '0;
            op_q     <= OP_FADD;
            size_q   <= SZ_32;
            addr_q   <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
        end else if (accept) begin
            status_q <= dec_status;
            result_q <= '0;
            op_q     <= op_e'(req_op);
            size_q   <= size_e'(req_size);
            addr_q   <= req_addr;
            opa_q    <= req_opa;
            opb_q    <= req_opb;
        end else if (state == S_MODIFY) begin
            result_q <= old_val;
        end
    end
endmodule

// File: rtl/atomic_completer_chk.sv
module atomic_completer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       cpl_valid,
    input logic [1:0] cpl_status,
    input logic       mem_we,
    input logic [1:0] dec_status
);
    assert_cpl_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ok_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_status == 2'b00) |=>
            (!cpl_valid ##1 !cpl_valid ##1 (cpl_valid && cpl_status == 2'b00)));

    assert_err_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_status != 2'b00) |=>
            (cpl_valid && cpl_status == $past(dec_status)));

    assert_no_write_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && dec_status != 2'b00) |=> !mem_we);

    assert_write_then_cpl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (cpl_valid && cpl_status == 2'b00));
endmodule

bind atomic_completer atomic_completer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .mem_we     (mem_we),
    .dec_status (dec_status)
);

// File: tb/atomic_completer_bench.sv
`timescale 1ns/1ps
module atomic_completer_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [1:0]   req_op, req_size;
    logic [7:0]   req_addr;
    logic [127:0] req_opa, req_opb;
    logic         cpl_valid;
    logic [1:0]   cpl_status;
    logic [127:0] cpl_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [127:0] model [16];

    always #5 clk = ~clk;

    atomic_completer #(.ADDR_W(8)) u_atomic_completer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
        .req_opa(req_opa), .req_opb(req_opb), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [1:0] size, input logic [7:0] addr,
                           input logic [127:0] a, input logic [127:0] b, input bit check_data);
        logic [127:0] mask, old, nv, exp_data;
        logic [1:0]   exp_st;
        int           bytes, sh, w, n;
        bit           busy_ok, wr;
        string        tag;
        bytes = 4 << size;
        w  = int'(addr[7:4]);
        sh = int'(addr[3:0]) * 8;
        mask = (size == 2'd0) ? 128'hFFFF_FFFF :
               (size == 2'd1) ? {64'h0, {64{1'b1}}} : {128{1'b1}};
        if (op == 2'd3 || size == 2'd3 || (size == 2'd2 && op != 2'd2)) exp_st = 2'b01;
        else if ((int'(addr[3:0]) % bytes) != 0)                        exp_st = 2'b10;
        else                                                            exp_st = 2'b00;
        tag = (exp_st == 2'b01) ? "R7" : (exp_st == 2'b10) ? "R6" :
              (op == 2'd0) ? "R2/size R5" : (op == 2'd1) ? "R3/size R5" : "R4/size R5";
        exp_data = '0;
        if (exp_st == 2'b00) begin
            old = (model[w] >> sh) & mask;
            exp_data = old;
            wr = 1'b1;
            case (op)
                2'd0:    nv = (old + (a & mask)) & mask;
                2'd1:    nv = a & mask;
                default: begin
                    nv = b & mask;
                    wr = (old == (a & mask));
                end
            endcase
            if (wr) model[w] = (model[w] & ~(mask << sh)) | (nv << sh);
        end
        @(negedge clk);
        req_op = op; req_size = size; req_addr = addr; req_opa = a; req_opb = b;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        busy_ok = 1'b1;
        while (!cpl_valid && n < 10) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        if (req_ready) busy_ok = 1'b0;
        chk("R9 busy while in flight", {127'd0, busy_ok}, 128'd1);
        chk("R8 completion latency", 128'(n), (exp_st == 2'b00) ? 128'd3 : 128'd1);
        chk({tag, " status"}, {126'd0, cpl_status}, {126'd0, exp_st});
        if (check_data) chk({tag, " data"}, cpl_data, exp_data);
        @(negedge clk);
        chk("R9 pulse ends and ready returns", {126'd0, cpl_valid, req_ready}, 128'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] a, b;
        int k;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_size = '0;
        req_addr = '0; req_opa = '0; req_opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {126'd0, req_ready, cpl_valid}, 128'd2);
        rst_n = 1'b1;

        // Fill every word with known data through 64-bit swaps.
        for (int w = 0; w < 16; w++) begin
            run_req(2'd1, 2'd1, 8'(w * 16),     128'(64'hA5A5_0000_0000_0000 + 64'(w)), '0, 1'b0);
            run_req(2'd1, 2'd1, 8'(w * 16 + 8), 128'(64'h0F0F_F0F0_1234_0000 ^ 64'(w * 7)), '0, 1'b0);
        end

        // Sweep opcode x size x lane offset x two operand patterns.
        k = 0;
        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int oi = 0; oi < 6; oi++)
                    for (int t = 0; t < 2; t++) begin
                        int offs [6] = '{0, 2, 4, 8, 12, 6};
                        int w;
                        k++;
                        w = (op * 4 + sz + oi + t) % 16;
                        a = {32'(k) * 32'h0123_4567, ~32'(k), 32'(k) * 32'h89AB_CDEF ^ 32'hFFFF_0000,
                             32'hFFFF_FFF0 + 32'(k)};
                        b = {~a[63:0], a[127:64] ^ 64'hDEAD_BEEF_0BAD_F00D};
                        if (op == 2 && t == 0) begin
                            logic [127:0] msk;
                            msk = (sz == 0) ? 128'hFFFF_FFFF :
                                  (sz == 1) ? {64'h0, {64{1'b1}}} : {128{1'b1}};
                            a = (model[w] >> (offs[oi] * 8)) & msk;
                        end
                        run_req(2'(op), 2'(sz), 8'(w * 16 + offs[oi]), a, b, 1'b1);
                    end

        // Carry-out wrap of a full-width add.
        run_req(2'd0, 2'd1, 8'h38, 128'(64'hFFFF_FFFF_FFFF_FFFF), '0, 1'b1);
        run_req(2'd0, 2'd0, 8'h44, 128'(32'hFFFF_FFFF), '0, 1'b1);

        // Read back every word with zero adds: covers untouched lanes and rejected requests.
        for (int w = 0; w < 16; w++) begin
            run_req(2'd0, 2'd1, 8'(w * 16),     '0, '0, 1'b1);
            run_req(2'd0, 2'd1, 8'(w * 16 + 8), '0, '0, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule